// File: doc/BRIEF.md
# Multi-channel DMA termination controller

This block holds the per-channel run state of a small DMA engine. Each channel has an enable bit, an interrupt enable, an end flag, a source pointer, a destination pointer and a transfer count. A shared operation register holds a master enable and two sticky abort flags: one for a non-maskable interrupt and one for an address error. Each cycle the block decides which channel, if any, may start one transfer unit. The data mover, the bus arbiter and the request sources are outside the block. The testbench stands in for them through the `dreq` and `xfer_done` pins.

A channel can end in two different ways. It ends normally when its count runs out: the end flag then sets, and the channel can raise an interrupt. It is halted when software drops its enable bit, the master enable is cleared, or an abort flag is raised: new grants then stop, and the end flag stays clear. A unit already in flight always finishes. Its pointers and count are updated as usual, and the bus is then released. The engine restarts only when software writes zero to the abort flags. Any channel that should stay idle has its enable cleared before that.

Software reaches the block through a single write port and a combinational read port. Channel `i` uses word addresses `4*i` (control), `4*i+1` (source), `4*i+2` (destination) and `4*i+3` (count). The shared register is at word `4*NCH`.

Top module: `dma_stop_ctl`

## Requirements
- R1: When `xfer_done[i]` completes an in-flight unit, the source and destination pointers each advance by STEP (4) and the count drops by one. If the count goes from 1 to 0, the end flag (control bit 2) sets.
- R2: `irq[i]` is high exactly while channel i's end flag and its interrupt enable (control bit 1) are both 1.
- R3: Writing 0 to a channel's enable (control bit 0) stops further grants to that channel and leaves its end flag at 0.
- R4: A one-cycle pulse on `nmi_in` sets shared bit 1, and a pulse on `aerr_in` sets shared bit 2. Both bits stay set while software writes 1 to them and clear only when software writes 0.
- R5: A channel is granted only if all of these hold: `dreq` is high, its enable is 1, its end flag is 0, its count is non-zero, the master enable (shared bit 0) is 1, both abort flags are 0, and no unit is in flight.
- R6: When an abort or a master-enable clear arrives while a unit is in flight, the unit completes on `xfer_done`. Its pointers and count are updated, and its end flag is not set.
- R7: The grant is one-hot or zero. The lowest-numbered eligible channel wins, and no grant is issued while a unit is in flight.
- R8: Once the abort flags are written to 0, eligible channels are granted again. A channel whose enable was cleared beforehand is not granted.
- R9: Writing 0 to control bit 2 clears the end flag, and `irq` drops in the same cycle. Writing 1 to that bit has no effect.
- R10: After reset, every register reads 0, no grant is issued, `bus_hold` is 0 and no interrupt is pending.
- R11: `bus_hold` is high while a grant is issued or a unit is in flight, and it is low otherwise. This includes the cycles after an aborted unit completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ABITS | Register word address for writes |
| wr_data | input | DW | Write data |
| rd_addr | input | ABITS | Register word address for reads |
| rd_data | output | DW | Read data (control reads {busy,end,ie,en}) |
| dreq | input | NCH | Per-channel transfer request from the request stub |
| xfer_done | input | NCH | Per-channel strobe marking the end of the unit in flight |
| nmi_in | input | 1 | Non-maskable interrupt event pulse |
| aerr_in | input | 1 | Address-error event pulse |
| grant | output | NCH | One-hot start strobe for the next unit |
| bus_hold | output | 1 | Bus is claimed by this engine |
| irq | output | NCH | Per-channel end-of-transfer interrupt request |

## Verification
The grant logic is driven with a table of request patterns while all channels are enabled. The table includes a single request, the full set, and mixed sets whose lowest request is at different positions. These patterns separate lowest-first priority from highest-first priority and from a plain OR of the requests. Each grant is then completed, so the count and pointer updates also show that only the winning channel advanced. Directed sequences set each stop cause on its own: count exhaustion, an enable clear, an abort during a unit in flight, an abort while idle, and a master-enable clear. Each sequence checks the end flag, the interrupt and the bus claim, which tells a normal finish apart from a halt. The restart sequences check that writing 1 to a sticky flag does nothing and writing 0 releases it.

// File: rtl/dma_stop_pkg.sv
`timescale 1ns/1ps
package dma_stop_pkg;
   // register selector within a channel's four-word window
   typedef enum logic [1:0] {
      RG_CTRL = 2'd0,
      RG_SRC  = 2'd1,
      RG_DST  = 2'd2,
      RG_CNT  = 2'd3
   } chreg_e;

   // control word bit positions
   localparam int CB_EN   = 0;
   localparam int CB_IE   = 1;
   localparam int CB_END  = 2;
   localparam int CB_BUSY = 3;

   // shared register bit positions
   localparam int GB_MASTER = 0;
   localparam int GB_NMI    = 1;
   localparam int GB_AERR   = 2;
endpackage

// File: rtl/dma_glb_ctl.sv
`timescale 1ns/1ps
module dma_glb_ctl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [2:0] wbits,
   input  logic       nmi_in,
   input  logic       aerr_in,
   output logic       master,
   output logic       nmi_flag,
   output logic       aerr_flag
);
   import dma_stop_pkg::*;

   logic clr_nmi, clr_aerr;
   assign clr_nmi  = wr && !wbits[GB_NMI];
   assign clr_aerr = wr && !wbits[GB_AERR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         master    <= 1'b0;
         nmi_flag  <= 1'b0;
         aerr_flag <= 1'b0;
      end else begin
         if (wr) master <= wbits[GB_MASTER];
         // hardware set wins over a same-cycle software clear
         if (nmi_in)       nmi_flag <= 1'b1;
         else if (clr_nmi) nmi_flag <= 1'b0;
         if (aerr_in)       aerr_flag <= 1'b1;
         else if (clr_aerr) aerr_flag <= 1'b0;
      end
   end

   // R4: an event pulse always leaves its flag set
   p_nmi_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_in |=> nmi_flag);
   // R4: a set flag survives any cycle without a zero write
   p_aerr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (aerr_flag && !clr_aerr) |=> aerr_flag);
endmodule

// File: rtl/dma_chan_st.sv
`timescale 1ns/1ps
module dma_chan_st #(
   parameter int AW   = 32,
   parameter int CW   = 16,
   parameter int DW   = 32,
   parameter int STEP = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr,
   input  dma_stop_pkg::chreg_e   wsel,
   input  logic [DW-1:0]          wdata,
   input  logic                   req,
   input  logic                   start,
   input  logic                   done,
   output logic                   en,
   output logic                   ie,
   output logic                   endf,
   output logic                   busy,
   output logic                   ready,
   output logic [AW-1:0]          sar,
   output logic [AW-1:0]          dar,
   output logic [CW-1:0]          cnt
);
   import dma_stop_pkg::*;

   localparam logic [AW-1:0] ASTEP = AW'(STEP);
   localparam logic [CW-1:0] CONE  = CW'(1);

   logic fin, exhaust, wr_ctrl;
   wire  unused_wbits = ^wdata;

   assign fin     = done && busy;
   assign exhaust = fin && (cnt == CONE);
   assign wr_ctrl = wr && (wsel == RG_CTRL);
   assign ready   = req && en && !endf && (cnt != '0) && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en   <= 1'b0;
         ie   <= 1'b0;
         endf <= 1'b0;
         busy <= 1'b0;
         sar  <= '0;
         dar  <= '0;
         cnt  <= '0;
      end else begin
         if (wr) begin
            unique case (wsel)
               RG_CTRL: begin
                  en <= wdata[CB_EN];
                  ie <= wdata[CB_IE];
               end
               RG_SRC:  sar <= wdata[AW-1:0];
               RG_DST:  dar <= wdata[AW-1:0];
               RG_CNT:  cnt <= wdata[CW-1:0];
               default: ;
            endcase
         end
         // completion of the unit in flight overrides a same-cycle write
         if (fin) begin
            sar <= sar + ASTEP;
            dar <= dar + ASTEP;
            cnt <= cnt - CONE;
         end
         if (start)     busy <= 1'b1;
         else if (done) busy <= 1'b0;
         if (exhaust)                         endf <= 1'b1;
         else if (wr_ctrl && !wdata[CB_END])  endf <= 1'b0;
      end
   end

   // R1: the end flag only ever rises with the count at zero
   p_end_at_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(endf) |-> (cnt == '0));
   // R1: each completed unit decrements the count by one
   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> (cnt == $past(cnt) - CONE));
   // R9: software can never set the end flag
   p_end_not_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fin && !endf) |=> !endf);
endmodule

// File: rtl/dma_pick.sv
`timescale 1ns/1ps
module dma_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   input  logic         allow,
   output logic [N-1:0] gnt
);
   logic [N-1:0] lower;

   assign lower[0] = 1'b0;
   for (genvar i = 1; i < N; i++) begin : g_prefix
      assign lower[i] = lower[i-1] | req[i-1];
   end
   for (genvar i = 0; i < N; i++) begin : g_gnt
      assign gnt[i] = allow && req[i] && !lower[i];
   end
endmodule

// File: rtl/dma_stop_ctl.sv
`timescale 1ns/1ps
module dma_stop_ctl #(
   parameter int NCH   = 4,
   parameter int AW    = 32,
   parameter int CW    = 16,
   parameter int DW    = 32,
   parameter int STEP  = 4,
   parameter int ABITS = $clog2(NCH*4+1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [ABITS-1:0] wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic [ABITS-1:0] rd_addr,
   output logic [DW-1:0]    rd_data,
   input  logic [NCH-1:0]   dreq,
   input  logic [NCH-1:0]   xfer_done,
   input  logic             nmi_in,
   input  logic             aerr_in,
   output logic [NCH-1:0]   grant,
   output logic             bus_hold,
   output logic [NCH-1:0]   irq
);
   import dma_stop_pkg::*;

   localparam int CHI_W = ABITS - 2;
   localparam logic [ABITS-1:0] GADDR = ABITS'(NCH*4);

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("dma_stop_ctl: NCH must be 1..8");
   end
   if (AW > DW || CW > DW || AW < 4) begin : g_bad_w
      $error("dma_stop_ctl: AW and CW must fit DW");
   end
   if (ABITS < $clog2(NCH*4+1) || CHI_W < 1) begin : g_bad_a
      $error("dma_stop_ctl: ABITS too small");
   end

   logic master, nmi_flag, aerr_flag, any_busy, allow, g_wr;
   logic [NCH-1:0] ch_en, ch_ie, ch_end, ch_busy, ch_ready, wr_ch;
   logic [AW-1:0]  ch_sar [NCH];
   logic [AW-1:0]  ch_dar [NCH];
   logic [CW-1:0]  ch_cnt [NCH];

   assign g_wr = wr_en && (wr_addr == GADDR);

   dma_glb_ctl u_glb (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (g_wr),
      .wbits     (wr_data[2:0]),
      .nmi_in    (nmi_in),
      .aerr_in   (aerr_in),
      .master    (master),
      .nmi_flag  (nmi_flag),
      .aerr_flag (aerr_flag)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign wr_ch[i] = wr_en && (wr_addr < GADDR)
                        && (wr_addr[ABITS-1:2] == CHI_W'(i));

      dma_chan_st #(.AW(AW), .CW(CW), .DW(DW), .STEP(STEP)) u_ch (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (wr_ch[i]),
         .wsel  (chreg_e'(wr_addr[1:0])),
         .wdata (wr_data),
         .req   (dreq[i]),
         .start (grant[i]),
         .done  (xfer_done[i]),
         .en    (ch_en[i]),
         .ie    (ch_ie[i]),
         .endf  (ch_end[i]),
         .busy  (ch_busy[i]),
         .ready (ch_ready[i]),
         .sar   (ch_sar[i]),
         .dar   (ch_dar[i]),
         .cnt   (ch_cnt[i])
      );

      assign irq[i] = ch_end[i] && ch_ie[i];

      // R9: a zero write to the end bit drops the interrupt at once
      p_end_clr_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_ch[i] && wr_addr[1:0] == 2'd0 && !wr_data[CB_END]
          && !(xfer_done[i] && ch_busy[i])) |=> !irq[i]);
   end

   assign any_busy = |ch_busy;
   assign allow    = master && !nmi_flag && !aerr_flag && !any_busy;

   dma_pick #(.N(NCH)) u_pick (
      .req   (ch_ready),
      .allow (allow),
      .gnt   (grant)
   );

   assign bus_hold = any_busy || (|grant);

   always_comb begin
      rd_data = '0;
      if (rd_addr == GADDR) begin
         rd_data[GB_MASTER] = master;
         rd_data[GB_NMI]    = nmi_flag;
         rd_data[GB_AERR]   = aerr_flag;
      end else if (rd_addr < GADDR) begin
         for (int i = 0; i < NCH; i++) begin
            if (rd_addr[ABITS-1:2] == CHI_W'(i)) begin
               unique case (chreg_e'(rd_addr[1:0]))
                  RG_CTRL: rd_data = DW'({ch_busy[i], ch_end[i], ch_ie[i], ch_en[i]});
                  RG_SRC:  rd_data = DW'(ch_sar[i]);
                  RG_DST:  rd_data = DW'(ch_dar[i]);
                  RG_CNT:  rd_data = DW'(ch_cnt[i]);
                  default: rd_data = '0;
               endcase
            end
         end
      end
   end

   // R7: at most one channel is started per cycle
   p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R5: a stopped engine issues no grant
   p_halt_no_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!master || nmi_flag || aerr_flag) |-> (grant == '0));
   // R7: a granted unit is in flight in the next cycle, blocking others
   p_grant_then_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant) |=> (bus_hold && grant == '0));
endmodule

// File: tb/dma_stop_ctl_test.sv
`timescale 1ns/1ps
module dma_stop_ctl_test;
   localparam int NCH = 4;
   localparam int DW  = 32;
   localparam int AB  = 5;
   localparam int GA  = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [AB-1:0]  wr_addr = '0;
   logic [DW-1:0]  wr_data = '0;
   logic [AB-1:0]  rd_addr = '0;
   logic [DW-1:0]  rd_data;
   logic [NCH-1:0] dreq = '0;
   logic [NCH-1:0] xfer_done = '0;
   logic           nmi_in = 1'b0;
   logic           aerr_in = 1'b0;
   logic [NCH-1:0] grant;
   logic           bus_hold;
   logic [NCH-1:0] irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dma_stop_ctl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .dreq(dreq), .xfer_done(xfer_done), .nmi_in(nmi_in),
      .aerr_in(aerr_in), .grant(grant), .bus_hold(bus_hold), .irq(irq)
   );

   // {dreq pattern, expected grant}, all channels enabled with large counts
   localparam logic [7:0] ARB_TAB [8] = '{
      8'b0000_0000, 8'b0001_0001, 8'b0010_0010, 8'b1100_0100,
      8'b1010_0010, 8'b1111_0001, 8'b1000_1000, 8'b0110_0010
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AB'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      rd_addr = AB'(a);
      #0.2;
      d = rd_data;
   endtask

   task automatic finish_unit(input logic [NCH-1:0] m);
      @(negedge clk);
      xfer_done = m; dreq = '0;
      @(negedge clk);
      xfer_done = '0;
   endtask

   initial begin
      #1000000;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      // R10: reset state
      rd(0, v);  chk("R10 ctrl0", v, 0);
      rd(GA, v); chk("R10 shared", v, 0);
      rd(7, v);  chk("R10 cnt1", v, 0);
      chk("R10 grant", 32'(grant), 0);
      chk("R10 bus_hold", 32'(bus_hold), 0);
      chk("R10 irq", 32'(irq), 0);
      rst_n = 1'b1;

      wr(GA, 1);
      wr(5, 32'h100);
      for (int c = 0; c < NCH; c++) begin
         wr(c*4+3, 100);
         wr(c*4, 1);
      end

      // R7 / R5: priority table
      for (int k = 0; k < 8; k++) begin
         logic [3:0] p, e;
         p = ARB_TAB[k][7:4];
         e = ARB_TAB[k][3:0];
         @(negedge clk);
         dreq = p;
         #1;
         chk($sformatf("R7 grant pattern %b", p), 32'(grant), 32'(e));
         chk("R11 hold with grant", 32'(bus_hold), 32'(e != 0));
         if (e != 0) begin
            @(negedge clk);
            chk("R7 no grant in flight", 32'(grant), 0);
            xfer_done = e; dreq = '0;
            @(negedge clk);
            xfer_done = '0;
         end else begin
            dreq = '0;
         end
      end
      rd(7, v);  chk("R1 cnt1 after 3 units", v, 97);
      rd(5, v);  chk("R1 src1 after 3 units", v, 32'h10C);
      rd(3, v);  chk("R7 cnt0 after 2 units", v, 98);
      rd(15, v); chk("R7 cnt3 after 1 unit", v, 99);

      // R1 / R2: count exhaustion on channel 2
      wr(11, 1);
      wr(8, 3);
      @(negedge clk); dreq = 4'b0100;
      #1 chk("R5 grant ch2", 32'(grant), 4);
      finish_unit(4'b0100);
      rd(8, v);  chk("R1 end flag set", v, 7);
      rd(11, v); chk("R1 cnt2 zero", v, 0);
      chk("R2 irq raised", 32'(irq), 4);
      dreq = 4'b0100;
      #1 chk("R5 ended channel not granted", 32'(grant), 0);
      dreq = '0;

      // R9: end bit write semantics
      wr(8, 7);
      chk("R9 write 1 keeps irq", 32'(irq), 4);
      rd(8, v); chk("R9 write 1 keeps end", v, 7);
      wr(8, 3);
      chk("R9 irq drops", 32'(irq), 0);
      rd(8, v); chk("R9 end cleared", v, 3);

      // R3: software halt of channel 0
      wr(0, 0);
      dreq = 4'b0001;
      #1 chk("R3 halted channel not granted", 32'(grant), 0);
      rd(0, v); chk("R3 end stays clear", v, 0);
      dreq = '0;

      // R6 / R4 / R11: abort during a unit in flight
      @(negedge clk); dreq = 4'b0010;
      #1 chk("R5 grant ch1", 32'(grant), 2);
      @(negedge clk); nmi_in = 1'b1;
      @(negedge clk); nmi_in = 1'b0;
      rd(GA, v); chk("R4 nmi flag set", v, 3);
      chk("R5 no grant after abort", 32'(grant), 0);
      chk("R11 hold while in flight", 32'(bus_hold), 1);
      xfer_done = 4'b0010;
      @(negedge clk); xfer_done = '0;
      rd(7, v); chk("R6 cnt1 updated", v, 96);
      rd(5, v); chk("R6 src1 updated", v, 32'h110);
      rd(4, v); chk("R6 end not set", v, 1);
      chk("R11 bus released", 32'(bus_hold), 0);
      chk("R5 still stopped", 32'(grant), 0);
      wr(GA, 3);
      rd(GA, v); chk("R4 write 1 keeps nmi", v, 3);
      chk("R4 no grant with nmi", 32'(grant), 0);
      wr(GA, 1);
      rd(GA, v); chk("R4 nmi cleared", v, 1);
      chk("R8 resume ch1", 32'(grant), 2);
      finish_unit(4'b0010);
      rd(7, v); chk("R8 cnt1 after resume", v, 95);

      // R4 / R8: address error while idle
      @(negedge clk); aerr_in = 1'b1;
      @(negedge clk); aerr_in = 1'b0;
      rd(GA, v); chk("R4 aerr flag set", v, 5);
      dreq = 4'b1010;
      #1 chk("R5 no grant with aerr", 32'(grant), 0);
      wr(4, 0);
      wr(GA, 1);
      chk("R8 disabled ch1 skipped", 32'(grant), 8);
      finish_unit(4'b1000);
      rd(15, v); chk("R8 cnt3 advanced", v, 98);

      // R6 / R5: master enable cleared
      wr(GA, 0);
      dreq = 4'b1000;
      #1 chk("R5 no grant without master", 32'(grant), 0);
      rd(12, v); chk("R6 end3 not set", v, 1);
      dreq = '0;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule